// File: doc/BRIEF.md
# Audio master clock divider

This block derives the two timing clocks of a serial audio link, the bit clock and the word (frame) clock, from a master clock. It is used when the local side drives the link. A three-bit ratio select gives the number of master-clock cycles in one audio frame. A three-bit divider select gives the bit-clock period, either as a fixed fraction of the master clock or as a set number of bit clocks per frame. A polarity input inverts the bit clock.

Some ratios are not powers of two (192, 384, 768 and 1152 master cycles per frame), so the divider can need an odd integer division. Settings that cannot give a clean waveform raise an error flag and silence both clocks. Any change of either select restarts the frame from its first cycle.

Top module: `audio_clkgen`

## Requirements
- R1: The ratio select sets the frame length in master-clock cycles: 001=128, 010=192, 011=256, 100=384, 101=512, 110=768, 111=1152, and 000 is taken as 256.
- R2: The divider select sets the bit-clock period D in master-clock cycles: 000 gives D=4, 001 gives D=8, 010 gives D=frame/32, 011 gives D=frame/64, 100 gives D=frame/128.
- R3: Counting master cycles k from a restart (k=0 on the first cycle after the edge that starts it), the uninverted bit clock is low while (k mod D) < D-floor(D/2) and high otherwise.
- R4: The word clock is low while (k mod frame) < frame/2 and high otherwise; each of its transitions falls on a cycle where the uninverted bit clock goes low.
- R5: For an odd D the low phase of the bit clock lasts one master cycle longer than its high phase.
- R6: With the polarity input at 1 the bit clock output is the complement of the R3 waveform, from the cycle after the input is sampled; a polarity change does not restart the counters.
- R7: Divider codes 101, 110 and 111, a D below 2, or a frame length that D does not divide into a whole number of bit clocks per half frame, set cfg_err to 1 and hold bit clock and word clock at 0.
- R8: A change of either select, sampled at a rising edge, restarts both counters so that the cycle after that edge is k=0.
- R9: During and after reset, before any setting is applied, bit clock, word clock and cfg_err are all 0 (the reset setting is ratio 000 with divider 000, polarity normal).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_sel | input | 3 | Master-cycles-per-frame select |
| bdiv_sel | input | 3 | Bit-clock rate select |
| bclk_inv | input | 1 | 1 inverts the bit clock output |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Word clock, one period per frame |
| cfg_err | output | 1 | Setting cannot be produced; clocks held low |

## Verification
Every input is captured at a rising master-clock edge, and the outputs decoded from the captured setting and the counters are valid for the whole of the following cycle, so a new select or polarity is visible one cycle after the edge that samples it and a restart shows k=0 in that same cycle. The bench changes inputs only on falling edges, advances its own cycle index and captured setting at each rising edge, and compares all three outputs at the next falling edge. Directed settings cover both odd divisions, every error cause and a mid-run polarity flip; seeded random settings and run lengths cover the rest.

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int CW = 11
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic [2:0] ratio_sel,
  input  logic [2:0] bdiv_sel,
  input  logic       bclk_inv,
  output logic       bclk,
  output logic       lrclk,
  output logic       cfg_err
);

  logic [2:0]    ratio_q, bdiv_q;
  logic          inv_q;
  logic [CW-1:0] bcnt, fcnt;
  logic [CW-1:0] frame_len, per, lo_len, half;
  logic          bad, restart;

  always_comb begin
    case (ratio_q)
      3'd1:    frame_len = CW'(128);
      3'd2:    frame_len = CW'(192);
      3'd4:    frame_len = CW'(384);
      3'd5:    frame_len = CW'(512);
      3'd6:    frame_len = CW'(768);
      3'd7:    frame_len = CW'(1152);
      default: frame_len = CW'(256);
    endcase
  end

  always_comb begin
    bad = 1'b0;
    per = CW'(4);
    case (bdiv_q)
      3'd0: begin per = CW'(4); bad = |frame_len[2:0]; end
      3'd1: begin per = CW'(8); bad = |frame_len[3:0]; end
      3'd2: begin per = frame_len >> 5; bad = |frame_len[4:0]; end
      3'd3: begin per = frame_len >> 6; bad = |frame_len[5:0]; end
      3'd4: begin per = frame_len >> 7; bad = |frame_len[6:0]; end
      default: bad = 1'b1;
    endcase
    if (per < CW'(2)) bad = 1'b1;
  end

  assign lo_len  = per - (per >> 1);
  assign half    = frame_len >> 1;
  assign restart = ({ratio_sel, bdiv_sel} != {ratio_q, bdiv_q}) || bad;

  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      ratio_q <= '0;
      bdiv_q  <= '0;
      inv_q   <= 1'b0;
      bcnt    <= '0;
      fcnt    <= '0;
    end else begin
      ratio_q <= ratio_sel;
      bdiv_q  <= bdiv_sel;
      inv_q   <= bclk_inv;
      if (restart) begin
        bcnt <= '0;
        fcnt <= '0;
      end else begin
        bcnt <= (bcnt == per - CW'(1))       ? '0 : bcnt + CW'(1);
        fcnt <= (fcnt == frame_len - CW'(1)) ? '0 : fcnt + CW'(1);
      end
    end
  end

  assign cfg_err = bad;
  assign bclk    = !bad && ((bcnt >= lo_len) ^ inv_q);
  assign lrclk   = !bad && (fcnt >= half);

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic       mclk,
  input logic       rst_n,
  input logic [2:0] ratio_sel,
  input logic [2:0] bdiv_sel,
  input logic       bclk_inv,
  input logic       bclk,
  input logic       lrclk,
  input logic       cfg_err
);

  assert_err_quiet_R7: assert property (@(posedge mclk) disable iff (!rst_n)
    cfg_err |-> (!bclk && !lrclk));

  assert_reserved_code_R7: assert property (@(posedge mclk) disable iff (!rst_n)
    (bdiv_sel > 3'd4) |=> (cfg_err && !bclk && !lrclk));

  assert_lr_on_fall_R4: assert property (@(posedge mclk) disable iff (!rst_n)
    (!$stable(lrclk) && !cfg_err) |-> (bclk == $past(bclk_inv)));

  assert_restart_R8: assert property (@(posedge mclk) disable iff (!rst_n)
    (!$stable(ratio_sel) || !$stable(bdiv_sel)) |=>
      (!lrclk && (cfg_err || bclk == $past(bclk_inv))));

endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
  .mclk(mclk), .rst_n(rst_n), .ratio_sel(ratio_sel), .bdiv_sel(bdiv_sel),
  .bclk_inv(bclk_inv), .bclk(bclk), .lrclk(lrclk), .cfg_err(cfg_err)
);

// File: tb/sim_audio_clkgen.sv
module sim_audio_clkgen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ratio_sel = 3'd0, bdiv_sel = 3'd0;
  logic       bclk_inv = 1'b1;
  logic       bclk, lrclk, cfg_err;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [2:0] m_ratio = 3'd0, m_div = 3'd0;
  logic       m_inv = 1'b0;
  int         k = 0;

  audio_clkgen u0 (
    .mclk(mclk), .rst_n(rst_n), .ratio_sel(ratio_sel), .bdiv_sel(bdiv_sel),
    .bclk_inv(bclk_inv), .bclk(bclk), .lrclk(lrclk), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) mclk = ~mclk;

  function automatic int fn_frame(input logic [2:0] r);
    case (r)
      3'd1: return 128;
      3'd2: return 192;
      3'd4: return 384;
      3'd5: return 512;
      3'd6: return 768;
      3'd7: return 1152;
      default: return 256;
    endcase
  endfunction

  function automatic int fn_div(input logic [2:0] r, input logic [2:0] d);
    int n, m;
    n = fn_frame(r);
    case (d)
      3'd0: return 4;
      3'd1: return 8;
      3'd2: m = 32;
      3'd3: m = 64;
      3'd4: m = 128;
      default: return 0;
    endcase
    if ((n % m) != 0 || (n / m) < 2) return 0;
    return n / m;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at k=%0d", tag, act, exp, k);
    end
  endtask

  task automatic compare();
    int d, n;
    string tb, tl;
    d = fn_div(m_ratio, m_div);
    n = fn_frame(m_ratio);
    if (d == 0) begin
      chk("R7 cfg_err", cfg_err, 1'b1);
      chk("R7 bclk held", bclk, 1'b0);
      chk("R7 lrclk held", lrclk, 1'b0);
    end else begin
      tb = (d % 2 == 1) ? "R2,R3,R5 bclk" : "R2,R3 bclk";
      if (m_inv) tb = {tb, " R6"};
      tl = "R1,R4 lrclk";
      if (k == 0) begin tb = {tb, " R8"}; tl = {tl, " R8"}; end
      chk("R7 cfg_err clear", cfg_err, 1'b0);
      chk(tb, bclk, ((k % d) >= (d - d/2)) ^ m_inv);
      chk(tl, lrclk, (k % n) >= (n/2));
    end
  endtask

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(posedge mclk);
      if ({ratio_sel, bdiv_sel} != {m_ratio, m_div} || fn_div(m_ratio, m_div) == 0)
        k = 0;
      else
        k++;
      m_ratio = ratio_sel;
      m_div   = bdiv_sel;
      m_inv   = bclk_inv;
      @(negedge mclk);
      compare();
    end
  endtask

  task automatic setup(input logic [2:0] r, input logic [2:0] d, input logic inv);
    ratio_sel = r;
    bdiv_sel  = d;
    bclk_inv  = inv;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 3; i++) begin
      @(negedge mclk);
      chk("R9 reset bclk", bclk, 1'b0);
      chk("R9 reset lrclk", lrclk, 1'b0);
      chk("R9 reset cfg_err", cfg_err, 1'b0);
    end
    bclk_inv = 1'b0;
    rst_n = 1'b1;
    run(600);
    setup(3'd7, 3'd4, 1'b0); run(2400);
    setup(3'd2, 3'd3, 1'b0); run(500);
    setup(3'd4, 3'd4, 1'b1); run(900);
    setup(3'd0, 3'd2, 1'b0); run(300);
    bclk_inv = 1'b1;         run(300);
    setup(3'd1, 3'd4, 1'b0); run(40);
    setup(3'd2, 3'd4, 1'b0); run(40);
    setup(3'd3, 3'd5, 1'b1); run(40);
    setup(3'd5, 3'd7, 1'b0); run(40);
    setup(3'd6, 3'd2, 1'b0); run(1600);
    setup(3'd6, 3'd1, 1'b0); run(1600);
    for (int s = 0; s < 30; s++) begin
      setup(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
      run(int'($urandom_range(300, 1500)));
      if ($urandom_range(0, 3) == 0) bclk_inv = ~bclk_inv;
      run(int'($urandom_range(300, 1500)));
    end
    finish_run();
  end
endmodule